// File: doc/BRIEF.md
# SAR Converter Timing Sequencer

This block is the digital timing core of a successive-approximation analog-to-digital converter. It turns the system clock into a slower converter clock through a power-of-two prescaler selected by a 3-bit code. It keeps the converter powered only while an enable input is high. After every power-up it waits a settling interval, then runs each conversion as a fixed sample-and-hold interval followed by one trial per result bit. The comparator, the trial DAC and the input multiplexer sit outside the block. The block drives the sample-hold control and the trial code. It reads back a single comparator bit.

A host raises `start` for one clock. `busy` then stays high while the hardware works, and the host keeps running. When the last bit is resolved, `eoc` pulses for one system clock and `result` takes its new value on the same edge. A combinational `clk_bad` output reports when the selected division puts the converter clock period outside 0.5 µs to 10 µs. It computes this for the system clock frequency given as a build parameter. Every pin is a plain control or status signal. No pin uses a valid/ready handshake, so nothing at the edge of the block can exert back-pressure.

Top module: `adc_seq_top`

## Requirements
- R1: One converter cycle lasts 2^code system clocks, where code is `clk_sel` (0 gives divide by 1, 7 gives divide by 128). The code is captured when `en` rises and again when a conversion is accepted.
- R2: While `en` is low the sequencer is off, `busy` and `sh_ctrl` are low, and `start` pulses are ignored. They are neither run nor remembered.
- R3: After `en` rises, no conversion begins for SETTLE_CYC converter cycles. A `start` seen during that interval is held. The conversion is accepted on the edge that ends the interval, so `busy` is first high SETTLE_CYC·2^code+1 clocks after the clock edge that saw `en` high.
- R4: `sh_ctrl` is high for exactly SAMPLE_CYC (4) converter cycles. It rises together with `busy`.
- R5: A conversion takes SAMPLE_CYC+RES_BITS (16) converter cycles. `busy` is high for exactly 16·2^code system clocks from the cycle after the accepting edge.
- R6: `trial` is zero outside the bit-resolution phase. During that phase it equals the bits kept so far plus the bit under test, tested from bit RES_BITS-1 down to bit 0. The first trial is therefore 0x800.
- R7: The value of `cmp_in` at the end of each resolution cycle decides the bit under test: 1 keeps it and 0 clears it. With an ideal comparator (`cmp_in` = trial ≤ input), `result` equals the input.
- R8: `eoc` is high for exactly one system clock. `result` changes only on that edge, and `busy` falls on the same edge.
- R9: A `start` while `busy` is high has no effect. The running conversion keeps its length, and no second conversion follows.
- R10: Lowering `en` during a conversion aborts it. `busy` is low on the next cycle, no `eoc` is produced, and `result` keeps its previous value.
- R11: Changing `clk_sel` during a conversion does not change that conversion's timing.
- R12: `clk_bad` is high exactly when 2^code·10^6/SYS_FREQ_KHZ ns is below 500 ns or above 10000 ns.
- R13: After reset `busy`, `sh_ctrl`, `eoc`, `trial` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter power enable |
| clk_sel | input | SEL_W (3) | Prescaler code, divide by 2^code |
| start | input | 1 | Conversion request pulse |
| cmp_in | input | 1 | Comparator decision, 1 = keep trial bit |
| sh_ctrl | output | 1 | Sample-hold control, high while sampling |
| trial | output | RES_BITS (12) | Code presented to the trial DAC |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | One-clock end-of-conversion pulse |
| result | output | RES_BITS (12) | Last completed conversion result |
| clk_bad | output | 1 | Selected converter clock period outside the valid range |

## Verification
The bench builds the block with SYS_FREQ_KHZ = 8000. This makes the range flag true for codes 0, 1 and 7 and false for codes 2 to 6, so both sides of both limits are exercised. SETTLE_CYC is set to 6 so that each power-up stays short, while the resolution and sample lengths keep their defaults of 12 and 4. With these values every divider code, including divide by 128, fits inside one short run. The exact cycle counts of the settling, sampling and total conversion intervals can then be compared against 2^code multiples for every code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SETTLE,
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV
  } seq_state_t;

  localparam longint unsigned PERIOD_MIN_NS = 64'd500;
  localparam longint unsigned PERIOD_MAX_NS = 64'd10000;

  // Converter period in ns is 2^code * 1e6 / f_kHz; compare without division.
  function automatic logic clk_code_bad(input int unsigned code,
                                        input longint unsigned f_khz);
    longint unsigned scaled;
    scaled = (64'd1 << code) * 64'd1000000;
    return (scaled < PERIOD_MIN_NS * f_khz) || (scaled > PERIOD_MAX_NS * f_khz);
  endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_zero,
  input  logic             restart,
  input  logic             sel_load,
  input  logic [SEL_W-1:0] sel_in,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] term;

  // Terminal count is 2^sel - 1; span[DIV_W] is set only for the largest code.
  assign span = {{DIV_W{1'b0}}, 1'b1} << sel_q;
  assign term = span[DIV_W-1:0] - DIV_W'(1);
  assign tick = (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_load) begin
      sel_q <= sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold_zero || restart || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_CYC = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start,
  input  logic       tick,
  input  logic       last_bit,
  output seq_state_t state,
  output logic       accept,
  output logic       conv_enter,
  output logic       conv_step,
  output logic       sel_load,
  output logic       pre_hold
);
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int SAMP_W = $clog2(SAMPLE_CYC + 1);

  seq_state_t       state_q;
  logic [SET_W-1:0] settle_q;
  logic [SAMP_W-1:0] samp_q;
  logic             pend_q;
  logic             want;
  logic             settle_done;
  logic             conv_done;

  assign want        = start || pend_q;
  assign settle_done = en && (state_q == ST_SETTLE) && tick &&
                       (settle_q == SET_W'(SETTLE_CYC - 1));
  assign accept      = en && want &&
                       ((state_q == ST_IDLE) || settle_done);
  assign conv_enter  = en && (state_q == ST_SAMPLE) && tick &&
                       (samp_q == SAMP_W'(SAMPLE_CYC - 1));
  assign conv_step   = en && (state_q == ST_CONV) && tick;
  assign conv_done   = conv_step && last_bit;
  assign sel_load    = (en && (state_q == ST_OFF)) || accept;
  assign pre_hold    = (state_q == ST_OFF) || !en;
  assign state       = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      settle_q <= '0;
      samp_q   <= '0;
      pend_q   <= 1'b0;
    end else if (!en) begin
      state_q  <= ST_OFF;
      settle_q <= '0;
      samp_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_q  <= ST_SETTLE;
          settle_q <= '0;
        end
        ST_SETTLE: begin
          pend_q <= pend_q | start;
          if (settle_done) begin
            pend_q   <= 1'b0;
            samp_q   <= '0;
            state_q  <= want ? ST_SAMPLE : ST_IDLE;
          end else if (tick) begin
            settle_q <= settle_q + SET_W'(1);
          end
        end
        ST_IDLE: begin
          if (accept) begin
            samp_q  <= '0;
            state_q <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          if (conv_enter) begin
            state_q <= ST_CONV;
          end else if (tick) begin
            samp_q <= samp_q + SAMP_W'(1);
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_conv,
  input  logic                load,
  input  logic                step,
  input  logic                cmp_in,
  output logic                last_bit,
  output logic [RES_BITS-1:0] trial,
  output logic [RES_BITS-1:0] result,
  output logic                eoc
);
  localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;

  logic [RES_BITS-1:0] sar_q;
  logic [RES_BITS-1:0] sar_next;
  logic [RES_BITS-1:0] probe;
  logic [IDX_W-1:0]    idx_q;

  assign probe    = {{(RES_BITS-1){1'b0}}, 1'b1} << idx_q;
  assign last_bit = (idx_q == '0);
  assign trial    = in_conv ? (sar_q | probe) : '0;

  always_comb begin
    sar_next = sar_q;
    sar_next[idx_q] = cmp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      idx_q  <= '0;
      result <= '0;
      eoc    <= 1'b0;
    end else begin
      eoc <= 1'b0;
      if (load) begin
        sar_q <= '0;
        idx_q <= IDX_W'(RES_BITS - 1);
      end else if (step) begin
        sar_q <= sar_next;
        if (last_bit) begin
          result <= sar_next;
          eoc    <= 1'b1;
        end else begin
          idx_q <= idx_q - IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/adc_clk_check.sv
module adc_clk_check
  import adc_seq_pkg::*;
#(
  parameter int          SEL_W        = 3,
  parameter int unsigned SYS_FREQ_KHZ = 8000
) (
  input  logic [SEL_W-1:0] clk_sel,
  output logic             clk_bad
);
  localparam int NCODE = 1 << SEL_W;

  logic [NCODE-1:0] bad_vec;

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    assign bad_vec[c] = clk_code_bad(c, longint'(SYS_FREQ_KHZ));
  end

  assign clk_bad = bad_vec[clk_sel];

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int          SEL_W        = 3,
  parameter int          RES_BITS     = 12,
  parameter int          SAMPLE_CYC   = 4,
  parameter int          SETTLE_CYC   = 16,
  parameter int unsigned SYS_FREQ_KHZ = 8000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SEL_W-1:0]    clk_sel,
  input  logic                start,
  input  logic                cmp_in,
  output logic                sh_ctrl,
  output logic [RES_BITS-1:0] trial,
  output logic                busy,
  output logic                eoc,
  output logic [RES_BITS-1:0] result,
  output logic                clk_bad
);
  seq_state_t state;
  logic       tick;
  logic       accept;
  logic       conv_enter;
  logic       conv_step;
  logic       sel_load;
  logic       pre_hold;
  logic       last_bit;

  adc_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_zero (pre_hold),
    .restart   (accept),
    .sel_load  (sel_load),
    .sel_in    (clk_sel),
    .tick      (tick)
  );

  adc_phase_ctrl #(
    .SAMPLE_CYC (SAMPLE_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .start      (start),
    .tick       (tick),
    .last_bit   (last_bit),
    .state      (state),
    .accept     (accept),
    .conv_enter (conv_enter),
    .conv_step  (conv_step),
    .sel_load   (sel_load),
    .pre_hold   (pre_hold)
  );

  adc_sar_core #(.RES_BITS(RES_BITS)) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_conv  (state == ST_CONV),
    .load     (conv_enter),
    .step     (conv_step),
    .cmp_in   (cmp_in),
    .last_bit (last_bit),
    .trial    (trial),
    .result   (result),
    .eoc      (eoc)
  );

  adc_clk_check #(
    .SEL_W        (SEL_W),
    .SYS_FREQ_KHZ (SYS_FREQ_KHZ)
  ) u_chk_clk (
    .clk_sel (clk_sel),
    .clk_bad (clk_bad)
  );

  assign sh_ctrl = (state == ST_SAMPLE);
  assign busy    = (state == ST_SAMPLE) || (state == ST_CONV);

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int SEL_W      = 3,
  parameter int RES_BITS   = 12,
  parameter int SAMPLE_CYC = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic [SEL_W-1:0]    clk_sel,
  input logic                sh_ctrl,
  input logic [RES_BITS-1:0] trial,
  input logic                busy,
  input logic                eoc,
  input logic [RES_BITS-1:0] result
);
  localparam int TOTAL = SAMPLE_CYC + RES_BITS;

  logic [SEL_W-1:0] sel_prev;
  logic [SEL_W-1:0] div_c;
  logic             busy_d;
  int unsigned      busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= '0;
      div_c    <= '0;
      busy_d   <= 1'b0;
      busy_cnt <= 0;
    end else begin
      sel_prev <= clk_sel;
      busy_d   <= busy;
      if (busy && !busy_d) begin
        busy_cnt <= 1;
        div_c    <= sel_prev;
      end else if (busy) begin
        busy_cnt <= busy_cnt + 1;
      end
    end
  end

  assert_eoc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  assert_eoc_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> !busy);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(result));

  assert_sample_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sh_ctrl |-> busy);

  assert_trial_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trial != '0) |-> (busy && !sh_ctrl));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  assert_duration_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (busy_cnt == (TOTAL << div_c)));

endmodule

bind adc_seq_top adc_seq_checker #(
  .SEL_W      (SEL_W),
  .RES_BITS   (RES_BITS),
  .SAMPLE_CYC (SAMPLE_CYC)
) u_seq_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .clk_sel (clk_sel),
  .sh_ctrl (sh_ctrl),
  .trial   (trial),
  .busy    (busy),
  .eoc     (eoc),
  .result  (result)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  localparam int RES    = 12;
  localparam int SAMP   = 4;
  localparam int SETTLE = 6;
  localparam int FKHZ   = 8000;
  localparam int TOTAL  = SAMP + RES;
  localparam logic [RES-1:0] MSB = 12'h800;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [2:0]     clk_sel = 3'd0;
  logic           start = 1'b0;
  logic           cmp_in;
  logic           sh_ctrl;
  logic [RES-1:0] trial;
  logic           busy;
  logic           eoc;
  logic [RES-1:0] result;
  logic           clk_bad;
  logic [RES-1:0] vin = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // Ideal comparator: keep the bit while the trial code does not exceed the input.
  always_comb cmp_in = (trial <= vin);

  adc_seq_top #(
    .SEL_W(3), .RES_BITS(RES), .SAMPLE_CYC(SAMP),
    .SETTLE_CYC(SETTLE), .SYS_FREQ_KHZ(FKHZ)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_sel(clk_sel), .start(start),
    .cmp_in(cmp_in), .sh_ctrl(sh_ctrl), .trial(trial), .busy(busy),
    .eoc(eoc), .result(result), .clk_bad(clk_bad)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // R13: values straight after reset
  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0 && sh_ctrl == 0 && eoc == 0, "R13 flags", {busy, sh_ctrl, eoc}, 0);
    chk(trial == 0, "R13 trial", trial, 0);
    chk(result == 0, "R13 result", result, 0);
  endtask

  // R2: start pulses while off are neither run nor held
  task automatic t_start_off();
    bit seen = 0;
    en = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || sh_ctrl) seen = 1;
    end
    chk(!seen, "R2 off ignores start", seen, 0);
  endtask

  // R3: settling wait with a held start; then check the conversion finishes
  task automatic t_power_up(input int sel, input logic [RES-1:0] v);
    int k = 0;
    int exp_k = SETTLE * (1 << sel) + 1;
    clk_sel = 3'(sel);
    vin = v;
    en = 1;
    while (!busy && k < 5000) begin
      @(negedge clk);
      k++;
      if (k == 1) start = 1;
      if (k == 2) start = 0;
    end
    chk(k == exp_k, "R3 settling length", k, exp_k);
    while (busy && k < 10000) begin
      @(negedge clk);
      k++;
    end
    chk(eoc == 1 && result == v, "R7 result after power-up", result, v);
  endtask

  // R1 R4 R5 R6 R7 R8 R9 R11: one conversion from idle
  task automatic t_convert(input int sel, input logic [RES-1:0] v,
                           input int new_sel, input bit mid_start);
    int d = 1 << sel;
    int k;
    int sh_n = 0;
    bit eoc_early = 0;
    bit extra = 0;
    logic [RES-1:0] exp2;
    clk_sel = 3'(sel);
    vin = v;
    start = 1;
    @(negedge clk);
    start = 0;
    k = 1;
    chk(busy == 1 && sh_ctrl == 1, "R4 sample starts with busy", {busy, sh_ctrl}, 3);
    chk(trial == 0, "R6 trial zero while sampling", trial, 0);
    exp2 = (v & MSB) | (MSB >> 1);
    while (busy && k < 5000) begin
      if (sh_ctrl) sh_n++;
      if (eoc) eoc_early = 1;
      if (k == SAMP * d + 1) chk(trial == MSB, "R6 first trial", trial, MSB);
      if (k == (SAMP + 1) * d + 1) chk(trial == exp2, "R6 second trial", trial, exp2);
      if (k == 3 && new_sel >= 0) clk_sel = 3'(new_sel);
      if (k == 5 && mid_start) start = 1;
      if (k == 6) start = 0;
      @(negedge clk);
      k++;
    end
    chk(sh_n == SAMP * d, "R4 sample length", sh_n, SAMP * d);
    chk(k - 1 == TOTAL * d, "R5 R1 R11 busy length", k - 1, TOTAL * d);
    chk(!eoc_early, "R8 no eoc while busy", eoc_early, 0);
    chk(eoc == 1, "R8 eoc with busy fall", eoc, 1);
    chk(result == v, "R7 result", result, v);
    @(negedge clk);
    chk(eoc == 0, "R8 eoc one clock", eoc, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) extra = 1;
    end
    chk(!extra, "R9 no second conversion", extra, 0);
  endtask

  // R10: abort mid conversion keeps old result
  task automatic t_abort(input logic [RES-1:0] old_v);
    bit eoc_seen = 0;
    clk_sel = 3'd1;
    vin = ~old_v;
    start = 1;
    @(negedge clk); start = 0;
    repeat (12) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(busy == 0, "R10 busy drops", busy, 0);
    for (int i = 0; i < 60; i++) begin
      if (eoc) eoc_seen = 1;
      @(negedge clk);
    end
    chk(!eoc_seen, "R10 no eoc", eoc_seen, 0);
    chk(result == old_v, "R10 result kept", result, old_v);
  endtask

  // R12: range flag for every code at 8 MHz
  task automatic t_clk_bad();
    for (int c = 0; c < 8; c++) begin
      real per_us;
      bit exp_bad;
      clk_sel = 3'(c);
      @(negedge clk);
      per_us = (2.0 ** c) / (FKHZ / 1000.0);
      exp_bad = (per_us < 0.5) || (per_us > 10.0);
      chk(clk_bad == exp_bad, $sformatf("R12 code %0d", c), clk_bad, exp_bad);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_start_off();
    t_power_up(0, 12'h3C5);
    @(negedge clk);
    t_convert(0, 12'hA5C, -1, 0);
    t_convert(2, 12'hFFF, -1, 0);
    t_convert(0, 12'h000, -1, 0);
    t_convert(3, 12'h7FF, -1, 0);
    t_convert(7, 12'h123, -1, 0);
    t_convert(1, 12'h801, 3, 0);
    t_convert(2, 12'h456, -1, 1);
    t_abort(12'h456);
    t_start_off();
    t_power_up(2, 12'h9E1);
    @(negedge clk);
    t_convert(5, 12'h2AB, 0, 1);
    t_clk_bad();
    finish_run();
  end

endmodule